// File: doc/BRIEF.md
# Signature Store-Load Forwarding Classifier

This block sits beside a store queue and sorts each incoming load, at decode time, into one of four paths before any address has been computed. Each memory operation carries a signature built from the color assigned to its base register and its displacement field. The block compares the load's signature with the signatures of the stores still queued ahead of it. If the youngest of those stores matches, the load is forwarded that store's data directly. In that case it counts as a zero-cycle load and as a buffer hit, and it needs no speculative recovery.

Loads that cannot be forwarded are steered by what lies ahead of them. With an empty queue the load may read the signature buffer right after decode. With non-matching or unresolved stores ahead, the load must wait for memory dependence resolution before it reads the buffer. A load whose own signature is not yet known takes the normal address-based path. The result is registered, so it appears one clock after the load is presented.

Queue entries are ordered by index: entry 0 is the oldest and the highest index is the youngest. Every queued store is older than the incoming load. Entries need not be contiguous.

Top module: `sigfwd_check`

## Requirements
- R1: While reset is asserted, `res_valid` is 0, `res_class` is 2'b00 and `res_data` is 0.
- R2: The result for a load presented with `ld_valid` high is visible on the outputs one clock later, and `res_valid` equals `ld_valid` of the previous clock.
- R3: A valid load with `ld_known` low is classed as normal path, code 2'b00.
- R4: A valid load with a known signature and no valid queue entry is classed as early buffer access, code 2'b10.
- R5: A valid load whose signature equals that of the youngest valid store is classed as early forward, code 2'b01. For this case `res_data` carries that store's data. The store must have `st_known` high.
- R6: When an older valid store matches but a younger valid store does not, the load is classed as delayed buffer access, code 2'b11. The same applies when no store matches and at least one is queued.
- R7: A valid store with `st_known` low never matches. Placed younger than a matching store, it counts as intervening and gives code 2'b11.
- R8: A match needs both the color and the displacement to be equal. A difference in either one alone gives no match.
- R9: `res_data` is 0 whenever `res_class` is not 2'b01.
- R10: Entries with `st_valid` low are ignored whatever their color, displacement or data hold. A matching invalid entry younger than the load's target store changes nothing.
- R11: When `ld_valid` was low, `res_valid` is 0, `res_class` is 2'b00 and `res_data` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | DEPTH (8) | Queue entry holds a store, bit i = entry i, 0 oldest |
| st_known | input | DEPTH (8) | Store base color has been assigned |
| st_color | input | DEPTH*CW (48) | Base colors, entry i at bits [i*CW +: CW] |
| st_disp | input | DEPTH*DW (96) | Displacements, entry i at bits [i*DW +: DW] |
| st_data | input | DEPTH*XW (256) | Store data, entry i at bits [i*XW +: XW] |
| ld_valid | input | 1 | A load is presented this clock |
| ld_known | input | 1 | Load base color has been assigned |
| ld_color | input | CW (6) | Load base color |
| ld_disp | input | DW (12) | Load displacement |
| res_valid | output | 1 | Result valid |
| res_class | output | 2 | 00 normal, 01 early forward, 10 early buffer, 11 delayed buffer |
| res_data | output | XW (32) | Forwarded store data for class 01, else 0 |

## Verification
The case that is hardest to reach from the ports is an older matching store shadowed by a younger intervening one. The intervening store may be non-matching or unresolved, and valid holes may sit between the two. Random queues rarely produce this when signatures are drawn from a wide range. The stimulus therefore draws colors and displacements from a set of four values each, so matches at several depths are common. Directed cycles then place an unresolved store, a one-field mismatch, or an invalid but matching entry directly above a matching store.

// File: rtl/sigfwd_pkg.sv
package sigfwd_pkg;
    typedef enum logic [1:0] {
        LDC_NORMAL  = 2'b00,
        LDC_FWD     = 2'b01,
        LDC_EARLY   = 2'b10,
        LDC_DELAYED = 2'b11
    } ld_class_e;
endpackage

// File: rtl/sigfwd_match.sv
// Per-entry signature comparator: an entry hits only if valid, resolved and
// equal in both color and displacement.
module sigfwd_match #(
    parameter int DEPTH = 8,
    parameter int CW    = 6,
    parameter int DW    = 12
) (
    input  logic [DEPTH-1:0]    st_valid,
    input  logic [DEPTH-1:0]    st_known,
    input  logic [DEPTH*CW-1:0] st_color,
    input  logic [DEPTH*DW-1:0] st_disp,
    input  logic [CW-1:0]       ld_color,
    input  logic [DW-1:0]       ld_disp,
    output logic [DEPTH-1:0]    hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic color_eq;
        logic disp_eq;
        assign color_eq = (st_color[i*CW +: CW] == ld_color);
        assign disp_eq  = (st_disp[i*DW +: DW] == ld_disp);
        assign hit[i]   = st_valid[i] & st_known[i] & color_eq & disp_eq;
    end
endmodule

// File: rtl/sigfwd_youngest.sv
// Finds the youngest (highest index) valid queue entry.
module sigfwd_youngest #(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] st_valid,
    output logic             any,
    output logic [IW-1:0]    idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_valid[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sigfwd_check.sv
module sigfwd_check
    import sigfwd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 6,
    parameter int DW    = 12,
    parameter int XW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEPTH-1:0]    st_valid,
    input  logic [DEPTH-1:0]    st_known,
    input  logic [DEPTH*CW-1:0] st_color,
    input  logic [DEPTH*DW-1:0] st_disp,
    input  logic [DEPTH*XW-1:0] st_data,
    input  logic                ld_valid,
    input  logic                ld_known,
    input  logic [CW-1:0]       ld_color,
    input  logic [DW-1:0]       ld_disp,
    output logic                res_valid,
    output logic [1:0]          res_class,
    output logic [XW-1:0]       res_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic            vld;
        ld_class_e       cls;
        logic [XW-1:0]   data;
    } res_t;

    logic [DEPTH-1:0] hit;
    logic             any_st;
    logic [IW-1:0]    y_idx;
    res_t             res_d, res_q;

    sigfwd_match #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u_match (
        .st_valid (st_valid),
        .st_known (st_known),
        .st_color (st_color),
        .st_disp  (st_disp),
        .ld_color (ld_color),
        .ld_disp  (ld_disp),
        .hit      (hit)
    );

    sigfwd_youngest #(.DEPTH(DEPTH)) u_young (
        .st_valid (st_valid),
        .any      (any_st),
        .idx      (y_idx)
    );

    // Only the youngest queued store may forward: anything younger than a
    // matching store would be an intervening store.
    always_comb begin
        res_d = '0;
        if (ld_valid) begin
            res_d.vld = 1'b1;
            if (!ld_known) begin
                res_d.cls = LDC_NORMAL;
            end else if (!any_st) begin
                res_d.cls = LDC_EARLY;
            end else if (hit[y_idx]) begin
                res_d.cls  = LDC_FWD;
                res_d.data = st_data[y_idx*XW +: XW];
            end else begin
                res_d.cls = LDC_DELAYED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_class = res_q.cls;
    assign res_data  = res_q.data;
endmodule

// File: rtl/sigfwd_check_sva.sv
module sigfwd_check_sva #(
    parameter int DEPTH = 8,
    parameter int XW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DEPTH-1:0] st_valid,
    input logic             ld_valid,
    input logic             ld_known,
    input logic             res_valid,
    input logic [1:0]       res_class,
    input logic [XW-1:0]    res_data
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> res_valid);
    a_r11_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> (!res_valid && res_class == 2'b00 && res_data == '0));
    a_r3_unknown_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_known) |=> res_class == 2'b00);
    a_r4_empty_early: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_known && st_valid == '0) |=> res_class == 2'b10);
    a_r9_data_only_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (res_class != 2'b01) |-> res_data == '0);
    a_r5_fwd_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_known && st_valid != '0) |=> res_class[0]);
endmodule

bind sigfwd_check sigfwd_check_sva #(.DEPTH(DEPTH), .XW(XW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .ld_valid  (ld_valid),
    .ld_known  (ld_known),
    .res_valid (res_valid),
    .res_class (res_class),
    .res_data  (res_data)
);

// File: tb/sigfwd_check_tb.sv
module sigfwd_check_tb;
    localparam int DEPTH = 8;
    localparam int CW    = 6;
    localparam int DW    = 12;
    localparam int XW    = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [DEPTH-1:0]    st_valid = '0;
    logic [DEPTH-1:0]    st_known = '0;
    logic [DEPTH*CW-1:0] st_color = '0;
    logic [DEPTH*DW-1:0] st_disp = '0;
    logic [DEPTH*XW-1:0] st_data = '0;
    logic                ld_valid = 1'b0;
    logic                ld_known = 1'b0;
    logic [CW-1:0]       ld_color = '0;
    logic [DW-1:0]       ld_disp = '0;
    logic                res_valid;
    logic [1:0]          res_class;
    logic [XW-1:0]       res_data;

    int checks = 0;
    int fails  = 0;

    always #2.5ns clk = ~clk;

    sigfwd_check #(.DEPTH(DEPTH), .CW(CW), .DW(DW), .XW(XW)) u_dut (.*);

    logic          e_vld;
    logic [1:0]    e_cls;
    logic [XW-1:0] e_data;
    string         e_tag;

    // Behavioural reference: walk from the youngest entry downward; the first
    // valid store decides the outcome.
    task automatic model(input string tag);
        bit decided = 0;
        e_vld = ld_valid; e_cls = 2'b00; e_data = '0; e_tag = tag;
        if (ld_valid && ld_known) begin
            e_cls = 2'b10;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!decided && st_valid[i]) begin
                    decided = 1;
                    if (st_known[i] && st_color[i*CW +: CW] == ld_color &&
                        st_disp[i*DW +: DW] == ld_disp) begin
                        e_cls = 2'b01;
                        e_data = st_data[i*XW +: XW];
                    end else begin
                        e_cls = 2'b11;
                    end
                end
            end
        end
        if (tag == "") begin
            if (!ld_valid) e_tag = "R11";
            else if (e_cls == 2'b00) e_tag = "R3";
            else if (e_cls == 2'b10) e_tag = "R4";
            else if (e_cls == 2'b01) e_tag = "R5";
            else e_tag = "R6";
        end
    endtask

    task automatic compare();
        checks++;
        if (res_valid !== e_vld || res_class !== e_cls || res_data !== e_data) begin
            fails++;
            $display("FAIL %s: got vld=%0b cls=%0b data=%h, expected vld=%0b cls=%0b data=%h",
                     e_tag, res_valid, res_class, res_data, e_vld, e_cls, e_data);
        end
    endtask

    task automatic step(input string tag);
        model(tag);
        @(negedge clk);
        compare();
        if (res_class != 2'b01) begin
            checks++;
            if (res_data !== '0) begin
                fails++;
                $display("FAIL R9: got data=%h, expected 0", res_data);
            end
        end
    endtask

    task automatic put(input int i, input bit v, input bit k, input int c, input int d,
                       input logic [XW-1:0] x);
        st_valid[i] = v; st_known[i] = k;
        st_color[i*CW +: CW] = CW'(c); st_disp[i*DW +: DW] = DW'(d);
        st_data[i*XW +: XW] = x;
    endtask

    task automatic clear_q();
        for (int i = 0; i < DEPTH; i++) put(i, 0, 0, 0, 0, '0);
    endtask

    task automatic load(input bit k, input int c, input int d);
        ld_valid = 1; ld_known = k; ld_color = CW'(c); ld_disp = DW'(d);
    endtask

    initial begin
        #1ms;
        fails++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        e_vld = 0; e_cls = 2'b00; e_data = '0; e_tag = "R1";
        compare();
        rst_n = 1'b1;

        step("R11");                                   // idle
        clear_q(); load(1, 3, 40); step("R4");         // empty queue
        load(0, 3, 40); step("R3");                    // load signature unknown
        put(2, 1, 1, 3, 40, 32'hA5A5_0001);
        load(1, 3, 40); step("R5");                    // youngest matches
        put(5, 1, 1, 3, 41, 32'h1111_2222); step("R6");// younger non-match
        put(5, 1, 0, 3, 40, 32'h1111_2222); step("R7");// unknown intervening
        put(5, 1, 0, 3, 40, 32'h1111_2222); put(2, 0, 0, 0, 0, '0);
        step("R7");                                    // unknown store alone never matches
        clear_q(); put(4, 1, 1, 3, 40, 32'hBEEF_0004);
        put(6, 1, 1, 2, 40, 32'h0);  step("R8");       // color differs only
        put(6, 1, 1, 3, 39, 32'h0);  step("R8");       // displacement differs only
        put(6, 0, 1, 7, 9, 32'hDEAD_0006); step("R10");// invalid entry ignored
        put(6, 0, 1, 3, 40, 32'hDEAD_0006); put(4, 1, 1, 3, 40, 32'hBEEF_0004);
        put(1, 1, 1, 5, 5, 32'h0); step("R10");        // gaps and invalid match
        ld_valid = 0; step("R11");
        load(1, 3, 40); ld_valid = 1; step("R2");

        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < DEPTH; i++)
                put(i, ($urandom % 3) != 0, ($urandom % 5) != 0, $urandom % 4,
                    $urandom % 4, $urandom);
            if ($urandom % 6 == 0) clear_q();
            ld_valid = ($urandom % 8) != 0;
            ld_known = ($urandom % 8) != 0;
            ld_color = CW'($urandom % 4);
            ld_disp  = DW'($urandom % 4);
            step("");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule